// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block drives the data bus of a flash device while an internal program or erase operation runs. When the device is idle, the bus carries the array byte. When a program or erase is started, the bus switches to a status word. Bit 6 of the status word inverts on every status read. Bit 5 reports that the operation has run past its pulse budget. A host polls these two bits to tell whether the operation is still running, has finished, or has failed.

Internally, one pulse is issued per clock while an operation runs.
- A normal program finishes after a configurable number of pulses.
- An erase finishes after a separate, larger number of pulses.
- A program that tries to turn a stored 0 into a 1 can never verify. It keeps pulsing until the maximum count is exceeded. The block then enters a failed state, with bit 5 set.
- The failed state holds until a reset command, which returns the bus to array reads.

The cell array itself and command decoding are outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low, the block is in array-read mode with the toggle bit cleared. The first status word after reset shows bit 6 = 0.
- R2: In array-read mode, `dout` equals `cell_data` in the same cycle. Reads in this mode leave the toggle bit unchanged.
- R3: A start in array-read mode enters the busy state at the next clock. The status word is then {bit7=0, bit6=toggle, bit5=fail, bits4..0=0}. If `prog_start` and `erase_start` are both high in the same cycle, the erase is taken.
- R4: While busy or failed, each cycle with `rd_strobe` high returns the current status word, and bit 6 is inverted from the next cycle on. Without a read, bit 6 holds.
- R5: A program is doomed when some bit set in `prog_data` is 0 in `cell_data`. A program that is not doomed shows exactly PROG_PULSES busy cycles, then returns to array-read mode.
- R6: An erase shows exactly ERASE_PULSES busy cycles, then returns to array-read mode.
- R7: A doomed program shows MAX_PULSES+1 busy cycles with bit 5 = 0. It then enters the failed state, with bit 5 = 1.
- R8: The failed state holds until `reset_cmd` is high. The block is then in array-read mode from the next cycle.
- R9: `prog_start`, `erase_start` and `reset_cmd` have no effect while busy. Start inputs have no effect while failed.
- R10: A read in the same cycle as completion, or in the same cycle as the reset command, still returns the status word and still inverts bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Start a program of `prog_data` |
| erase_start | input | 1 | Start an erase |
| prog_data | input | 8 | Byte to be programmed |
| cell_data | input | 8 | Byte currently stored at the target |
| rd_strobe | input | 1 | Bus read in this cycle |
| reset_cmd | input | 1 | Reset command, leaves the failed state |
| dout | output | 8 | Array byte or status word |

## Verification
A status read can land in the same cycle as the end of an operation: the last busy pulse of a program or erase, or the reset command that leaves the failed state. The bench raises `rd_strobe` exactly in those cycles. It expects the status word in that cycle and array data in the next. It also expects bit 6 to show the inversion when the next operation's status appears. A cycle-accurate behavioural model judges every clock. Explicit counts of busy cycles confirm the pulse budgets.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FAIL  = 2'd2
  } op_state_e;
endpackage

// File: rtl/flash_pulse_ctr.sv
module flash_pulse_ctr #(
  parameter int MAX_PULSES = 40,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)
      cnt_d = '0;
    else if (en && cnt != CW'(MAX_PULSES))
      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr || en)
      cnt <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_PULSES)); // R7
endmodule

// File: rtl/flash_toggle_reg.sv
module flash_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic status_mode,
  input  logic rd_strobe,
  output logic tog
);
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = status_mode && rd_strobe;
    tog_d  = ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tog <= 1'b0;
    else if (tog_en)
      tog <= tog_d;
  end

  AST_TOG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && rd_strobe) |=> (tog != $past(tog))); // R4
  AST_TOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_mode || !rd_strobe) |=> $stable(tog)); // R2
endmodule

// File: rtl/flash_op_fsm.sv
module flash_op_fsm
  import flash_stat_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PROG_PULSES  = 5,
  parameter int ERASE_PULSES = 20,
  parameter int MAX_PULSES   = 40,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_start,
  input  logic          erase_start,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] cell_data,
  input  logic          reset_cmd,
  input  logic [CW-1:0] cnt,
  output op_state_e     state,
  output logic          cnt_clr,
  output logic          cnt_en
);
  op_state_e state_d;
  logic      is_erase, is_erase_d;
  logic      doomed, doomed_d;
  logic      op_en;
  logic      hit_target;

  always_comb begin
    if (is_erase)
      hit_target = (cnt == CW'(ERASE_PULSES - 1));
    else
      hit_target = !doomed && (cnt == CW'(PROG_PULSES - 1));
  end

  always_comb begin
    state_d    = state;
    is_erase_d = is_erase;
    doomed_d   = doomed;
    op_en      = 1'b0;
    cnt_clr    = 1'b0;
    cnt_en     = 1'b0;
    unique case (state)
      ST_ARRAY: begin
        if (erase_start || prog_start) begin
          state_d    = ST_BUSY;
          op_en      = 1'b1;
          cnt_clr    = 1'b1;
          is_erase_d = erase_start;
          doomed_d   = !erase_start && (|(prog_data & ~cell_data));
        end
      end
      ST_BUSY: begin
        cnt_en = 1'b1;
        if (hit_target)
          state_d = ST_ARRAY;
        else if (cnt == CW'(MAX_PULSES))
          state_d = ST_FAIL;
      end
      ST_FAIL: begin
        if (reset_cmd)
          state_d = ST_ARRAY;
      end
      default: state_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= ST_ARRAY;
    else
      state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_erase <= 1'b0;
      doomed   <= 1'b0;
    end else if (op_en) begin
      is_erase <= is_erase_d;
      doomed   <= doomed_d;
    end
  end

  AST_PROG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !is_erase && !doomed && cnt == CW'(PROG_PULSES - 1))
      |=> state == ST_ARRAY); // R5
  AST_ERASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && is_erase && cnt == CW'(ERASE_PULSES - 1))
      |=> state == ST_ARRAY); // R6
  AST_DOOM_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && doomed && cnt == CW'(MAX_PULSES))
      |=> state == ST_FAIL); // R7
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && !reset_cmd) |=> state == ST_FAIL); // R8
  AST_FAIL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && reset_cmd) |=> state == ST_ARRAY); // R8
  AST_BUSY_OP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |=> ($stable(is_erase) && $stable(doomed))); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARRAY && (prog_start || erase_start)) |=> state == ST_BUSY); // R3
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PROG_PULSES  = 5,
  parameter int ERASE_PULSES = 20,
  parameter int MAX_PULSES   = 40,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_start,
  input  logic          erase_start,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] cell_data,
  input  logic          rd_strobe,
  input  logic          reset_cmd,
  output logic [DW-1:0] dout
);
  localparam int CW       = $clog2(MAX_PULSES + 1);
  localparam int TOG_BIT  = 6;
  localparam int FAIL_BIT = 5;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  op_state_e     state;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;
  logic          tog;
  logic          status_mode;

  assign status_mode = (state != ST_ARRAY);

  flash_op_fsm #(
    .DW(DW), .PROG_PULSES(PROG_PULSES),
    .ERASE_PULSES(ERASE_PULSES), .MAX_PULSES(MAX_PULSES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .prog_start(prog_start), .erase_start(erase_start),
    .prog_data(prog_data), .cell_data(cell_data),
    .reset_cmd(reset_cmd), .cnt(cnt),
    .state(state), .cnt_clr(cnt_clr), .cnt_en(cnt_en)
  );

  flash_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_ctr (
    .clk(clk), .rst_n(rst_int_n),
    .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  flash_toggle_reg u_tog (
    .clk(clk), .rst_n(rst_int_n),
    .status_mode(status_mode), .rd_strobe(rd_strobe), .tog(tog)
  );

  always_comb begin
    if (status_mode) begin
      dout           = '0;
      dout[TOG_BIT]  = tog;
      dout[FAIL_BIT] = (state == ST_FAIL);
    end else begin
      dout = cell_data;
    end
  end

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_ARRAY) |-> dout == cell_data); // R2
  AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_BUSY) |-> !dout[FAIL_BIT]); // R7
endmodule

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
  localparam int PP = 5, EP = 20, MP = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_start = 1'b0, erase_start = 1'b0, rd_strobe = 1'b0, reset_cmd = 1'b0;
  logic [7:0] prog_data = 8'h00, cell_data = 8'h00;
  logic [7:0] dout;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  flash_status_gen #(.PROG_PULSES(PP), .ERASE_PULSES(EP), .MAX_PULSES(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
    .prog_data(prog_data), .cell_data(cell_data), .rd_strobe(rd_strobe),
    .reset_cmd(reset_cmd), .dout(dout));

  // Behavioural reference: 0 array, 1 busy, 2 failed
  int m_st = 0, m_cnt = 0;
  bit m_erase = 0, m_doom = 0, m_tog = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_tog = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (erase_start || prog_start) begin
             m_st = 1; m_cnt = 0; m_erase = erase_start;
             m_doom = !erase_start && ((prog_data & ~cell_data) != 0);
           end
        1: begin
             if (rd_strobe) m_tog = !m_tog;
             if (m_cnt + 1 == (m_erase ? EP : (m_doom ? -1 : PP))) m_st = 0;
             else if (m_cnt == MP) m_st = 2;
             m_cnt++;
           end
        default: begin
             if (rd_strobe) m_tog = !m_tog;
             if (reset_cmd) m_st = 0;
           end
      endcase
    end
  end

  function automatic logic [7:0] model_out();
    if (m_st == 0) return cell_data;
    return {1'b0, m_tog, (m_st == 2), 5'b0};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) chk(dout, model_out(), cur_req);

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic cyc(input bit ps, input bit es, input logic [7:0] pd,
                     input logic [7:0] cd, input bit rd, input bit rc);
    @(posedge clk); #1;
    prog_start = ps; erase_start = es; prog_data = pd; cell_data = cd;
    rd_strobe = rd; reset_cmd = rc;
  endtask

  // counts samples (taken 3 ns after an edge) while cond on dout holds
  task automatic count_busy(input logic [7:0] cd, input bit use_fail, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      cyc(0, 0, 8'h00, cd, i[0], 0);
      #2;
      if (use_fail ? (dout[5] == 1'b0) : (dout !== cd)) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    cur_req = "R1";
    rst_n = 1'b0;
    cell_data = 8'h3C;
    #1; chk(dout, 8'h3C, "R1");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) cyc(0, 0, 8'h00, 8'h3C, 0, 0);

    cur_req = "R2";
    for (int i = 0; i < 6; i++) cyc(0, 0, 8'h00, 8'(8'h11 * i), 1, 1);

    cur_req = "R5";
    cyc(1, 0, 8'h0F, 8'hFF, 0, 0);
    count_busy(8'hFF, 0, n);
    checks++; if (n != PP) begin errors++; $display("FAIL R5: busy cycles actual %0d expected %0d", n, PP); end

    cur_req = "R3";
    cyc(0, 0, 8'h00, 8'hFF, 0, 0);
    cyc(1, 1, 8'h80, 8'h7F, 0, 0);
    cur_req = "R6";
    count_busy(8'h7F, 0, n);
    checks++; if (n != EP) begin errors++; $display("FAIL R6: busy cycles actual %0d expected %0d", n, EP); end

    cur_req = "R10";
    cyc(1, 0, 8'h01, 8'hFF, 0, 0);
    for (int i = 0; i < PP; i++) cyc(0, 0, 8'h00, 8'hFF, (i == PP - 1), 0);
    cyc(0, 0, 8'h00, 8'hFF, 0, 0);
    cyc(0, 1, 8'h00, 8'hFF, 0, 0);
    cyc(0, 0, 8'h00, 8'hFF, 0, 0); #2;
    cur_req = "R4";
    chk(dout, {1'b0, m_tog, 6'b0}, "R10");
    for (int i = 0; i < EP + 2; i++) cyc(0, 0, 8'h00, 8'hFF, (i % 3 == 0), 0);

    cur_req = "R7";
    cyc(1, 0, 8'h81, 8'h3C, 0, 0);
    count_busy(8'h3C, 1, n);
    checks++; if (n != MP + 1) begin errors++; $display("FAIL R7: busy cycles actual %0d expected %0d", n, MP + 1); end

    cur_req = "R8";
    for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, 8'h3C, 1, 0);
    cur_req = "R9";
    cyc(1, 1, 8'h00, 8'hFF, 0, 0);
    cyc(0, 0, 8'h00, 8'hFF, 0, 0); #2;
    chk(dout[5], 1'b1, "R9");
    cur_req = "R10";
    cyc(0, 0, 8'h00, 8'hFF, 1, 1);
    cyc(0, 0, 8'h00, 8'h5A, 0, 0); #2;
    chk(dout, 8'h5A, "R8");

    cur_req = "R9";
    cyc(0, 1, 8'h00, 8'hFF, 0, 0);
    for (int i = 0; i < EP; i++) cyc((i == 2), (i == 3), 8'h00, 8'hFF, 0, (i == 4));
    repeat (4) cyc(0, 0, 8'h00, 8'hC3, 0, 0);
    #2; chk(dout, 8'hC3, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule